// File: doc/BRIEF.md
# Interval Timer with Filtered Edge Capture

This block is an 8-bit up-counter with a small register port. It counts enables from one of four prescaled sources. Three of them come from a free-running divider on the system clock. The fourth comes from an external watch-clock tick, halved. Each wrap from 0xFF to 0x00 raises an overflow status flag. The overflow can also raise an interrupt request flag, and a separate enable bit decides whether that request drives the interrupt output.

In capture mode the capture pin is synchronised and edge-detected. A rising edge copies the running count into a rising-capture register and sets its status flag. A falling edge does the same with a separate falling-capture register and flag. A selectable noise canceller sits in that path. It admits a new pin level only after the level has been sampled unchanged on five consecutive sample ticks, so short pulses are dropped and accepted edges arrive late.

The pin is gated by the mode bit before it is synchronised. Writing the mode bit while the pin is high therefore produces a capture, just as a real edge would. Software must expect this spurious capture and clear its flag.

Top module: `capture_timer`

## Requirements
- R1: After reset every register reads 0x00, `irq_o` is 0, and the counter runs from the divide-by-64 source.
- R2: Bits [1:0] of CTRL (address 0) select the count source: 00 = clock/64, 01 = clock/32, 10 = clock/2, 11 = every second `watch_tick` pulse. Over any window whose length is a multiple of the source period, the counter advances by exactly the window length divided by that period.
- R3: The counter (address 2) advances by exactly one per source enable. A wrap from 0xFF to 0x00 sets STAT bit 0 (STAT is address 1).
- R4: A wrap sets STAT bit 1 (the interrupt request) only while CTRL bit 2 is 1.
- R5: `irq_o` is 1 only while STAT bit 1 and CTRL bit 5 are both 1, one cycle after they are.
- R6: While CTRL bit 3 (capture mode) is 1, a rising pin edge copies the counter into address 3 and sets STAT bit 2. A falling edge copies the counter into address 4 and sets STAT bit 3. While CTRL bit 3 is 0, the pin is ignored.
- R7: With CTRL bit 4 set, a pin level reaches the edge detector only after five consecutive equal samples, one sample every second clock. A pulse lasting fewer samples causes no capture, and no capture appears within four clocks of an edge.
- R8: Setting CTRL bit 3 while the pin is high yields a rising capture. Clearing it while the pin is high yields a falling capture.
- R9: Writing 0 to a STAT bit clears it and writing 1 leaves it unchanged. If a set event and a clearing write fall in the same cycle, the bit ends up set.
- R10: Writes to the counter address are ignored.
- R11: Changing the source select does not alter the count value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| watch_tick | input | 1 | One-cycle watch-clock tick |
| cap_pin | input | 1 | Asynchronous capture input |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data, one cycle after `addr` |
| irq_o | output | 1 | Registered interrupt output |

## Verification
A status flag can receive its set event and a software clear in the same clock cycle. The bench provokes this by raising the pin with the noise canceller off. It then issues the clearing STAT write so that the write lands on the exact edge where the rising-capture flag is set, three edges after the pin change. The result is judged by reading STAT afterwards: the rising flag must still be 1, while the other bits cleared by the same write must stay 0.

// File: rtl/capture_timer_pkg.sv
package capture_timer_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RCAP = 3'd3;
  localparam logic [ADDR_W-1:0] A_FCAP = 3'd4;

  typedef enum logic [1:0] {
    SRC_DIV_SLOW = 2'b00,
    SRC_DIV_MID  = 2'b01,
    SRC_DIV_FAST = 2'b10,
    SRC_WATCH    = 2'b11
  } src_e;

  typedef struct packed {
    logic irq_en;
    logic nc_en;
    logic cap_mode;
    logic ovf_ie;
    src_e src;
  } ctrl_t;

  localparam int STAT_BITS = 4;
endpackage

// File: rtl/capture_timer_prescaler.sv
module capture_timer_prescaler
  import capture_timer_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic watch_tick,
  input  src_e src,
  output logic cnt_tick,
  output logic smp_tick
);
  logic [DIV_W-1:0] div_q;
  logic             half_q;
  logic             src_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      half_q <= 1'b0;
    end else begin
      div_q <= div_q + 1'b1;
      if (watch_tick) half_q <= ~half_q;
    end
  end

  always_comb begin
    unique case (src)
      SRC_DIV_SLOW: src_en = &div_q;
      SRC_DIV_MID:  src_en = &div_q[DIV_W-2:0];
      SRC_DIV_FAST: src_en = div_q[0];
      default:      src_en = watch_tick & half_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_tick <= 1'b0;
      smp_tick <= 1'b0;
    end else begin
      cnt_tick <= src_en;
      smp_tick <= div_q[0];
    end
  end
endmodule

// File: rtl/capture_timer_front.sv
module capture_timer_front #(
  parameter int SYNC_STAGES = 2,
  parameter int NC_SAMPLES  = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_gated,
  input  logic smp_tick,
  input  logic nc_en,
  output logic rise,
  output logic fall
);
  localparam int HIST_W = NC_SAMPLES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HIST_W-1:0]      hist_q;
  logic                   flt_q;
  logic                   prev_q;
  logic                   lvl;
  logic [NC_SAMPLES-1:0]  win;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= pin_gated;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign win = {hist_q, sync_q[SYNC_STAGES-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      flt_q  <= 1'b0;
    end else if (smp_tick) begin
      hist_q <= win[HIST_W-1:0];
      if (&win)       flt_q <= 1'b1;
      else if (~|win) flt_q <= 1'b0;
    end
  end

  assign lvl = nc_en ? flt_q : sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/capture_timer.sv
module capture_timer
  import capture_timer_pkg::*;
#(
  parameter int DIV_W       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int NC_SAMPLES  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              watch_tick,
  input  logic              cap_pin,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] CNT_MAX = {DATA_W{1'b1}};

  ctrl_t                 ctrl_q;
  logic [DATA_W-1:0]     cnt_q, rcap_q, fcap_q;
  logic [STAT_BITS-1:0]  stat_q, stat_d, stat_set;
  logic                  cnt_tick, smp_tick, wrap, rise, fall, stat_wr;
  logic                  unused_wd;

  assign unused_wd = ^wr_data[DATA_W-1:$bits(ctrl_t)];

  capture_timer_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .watch_tick(watch_tick), .src(ctrl_q.src),
    .cnt_tick(cnt_tick), .smp_tick(smp_tick)
  );

  capture_timer_front #(.SYNC_STAGES(SYNC_STAGES), .NC_SAMPLES(NC_SAMPLES)) u_front (
    .clk(clk), .rst(rst), .pin_gated(cap_pin & ctrl_q.cap_mode),
    .smp_tick(smp_tick), .nc_en(ctrl_q.nc_en), .rise(rise), .fall(fall)
  );

  assign wrap    = cnt_tick && (cnt_q == CNT_MAX);
  assign stat_wr = wr_en && (addr == A_STAT);
  assign stat_set = {fall, rise, wrap & ctrl_q.ovf_ie, wrap};

  always_comb begin
    for (int i = 0; i < STAT_BITS; i++)
      stat_d[i] = stat_set[i] | (stat_q[i] & ~(stat_wr & ~wr_data[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      rcap_q <= '0;
      fcap_q <= '0;
      stat_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (wr_en && addr == A_CTRL) ctrl_q <= ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
      if (cnt_tick) cnt_q <= cnt_q + 1'b1;
      if (rise) rcap_q <= cnt_q;
      if (fall) fcap_q <= cnt_q;
      stat_q <= stat_d;
      irq_o  <= stat_q[1] & ctrl_q.irq_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      unique case (addr)
        A_CTRL:  rd_data <= DATA_W'(ctrl_q);
        A_STAT:  rd_data <= DATA_W'(stat_q);
        A_CNT:   rd_data <= cnt_q;
        A_RCAP:  rd_data <= rcap_q;
        A_FCAP:  rd_data <= fcap_q;
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/capture_timer_chk.sv
module capture_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] cnt,
  input logic       ovf_flag,
  input logic       req_flag,
  input logic       rise_flag,
  input logic       rise,
  input logic       fall,
  input logic       irq_en,
  input logic       irq_o
);
  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 8'd1));

  assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt) == 8'hFF && cnt == 8'h00) |-> ovf_flag);

  assert_req_with_ovf_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(req_flag) |-> ovf_flag);

  assert_irq_gate_R5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(req_flag && irq_en));

  assert_rise_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
    rise |=> rise_flag);

  assert_edges_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(rise && fall));
endmodule

bind capture_timer capture_timer_chk u_chk (
  .clk(clk), .rst(rst), .cnt(cnt_q), .ovf_flag(stat_q[0]), .req_flag(stat_q[1]),
  .rise_flag(stat_q[2]), .rise(rise), .fall(fall), .irq_en(ctrl_q.irq_en),
  .irq_o(irq_o)
);

// File: tb/capture_timer_bench.sv
`timescale 1ns/1ps
module capture_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       watch_tick = 1'b0;
  logic       cap_pin = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;
  logic watch_on = 1'b1;
  int wcnt = 0;

  capture_timer u_capture_timer (
    .clk(clk), .rst(rst), .watch_tick(watch_tick), .cap_pin(cap_pin),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (watch_on) begin
      wcnt <= (wcnt == 7) ? 0 : wcnt + 1;
      watch_tick <= (wcnt == 7);
    end else begin
      watch_tick <= 1'b0;
    end
  end

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] wt;
    logic [7:0]  dlt;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{8'h00, 16'd256, 8'd4},
    '{8'h01, 16'd256, 8'd8},
    '{8'h02, 16'd64,  8'd32},
    '{8'h03, 16'd256, 8'd16},
    '{8'h02, 16'd100, 8'd50}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1600000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] a, b, v, v2;
    idle(5);
    rst = 1'b0;
    // R1 reset state
    rd(3'd0, a); chk("R1 ctrl", a, 8'h00);
    rd(3'd1, a); chk("R1 stat", a, 8'h00);
    rd(3'd3, a); chk("R1 rcap", a, 8'h00);
    rd(3'd4, a); chk("R1 fcap", a, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    rd(3'd2, a); idle(127); rd(3'd2, b);
    chk("R1 default /64", b - a, 8'd2);

    // R2 source select vectors
    foreach (VEC[i]) begin
      wr(3'd0, VEC[i].ctrl); idle(4);
      rd(3'd2, a); idle(int'(VEC[i].wt) - 1); rd(3'd2, b);
      chk($sformatf("R2 vector %0d", i), b - a, VEC[i].dlt);
    end

    // R3 / R4 overflow without request
    wr(3'd0, 8'h02); wr(3'd1, 8'h00); idle(530);
    rd(3'd1, a); chk("R3 R4 ovf only", a & 8'h03, 8'h01);

    // R5 interrupt path
    wr(3'd0, 8'h26); wr(3'd1, 8'h00); idle(530);
    rd(3'd1, a); chk("R4 request set", a & 8'h03, 8'h03);
    chk("R5 irq high", {7'd0, irq_o}, 8'h01);
    watch_on = 1'b0;
    wr(3'd0, 8'h27); idle(2);
    wr(3'd0, 8'h07); idle(2);
    chk("R5 irq gated off", {7'd0, irq_o}, 8'h00);
    wr(3'd1, 8'hFD);
    rd(3'd1, a); chk("R9 write1 keeps write0 clears", a & 8'h03, 8'h01);

    // R6 / R8 with frozen counter
    rd(3'd2, v);
    wr(3'd0, 8'h03); wr(3'd1, 8'h00);
    cap_pin = 1'b1; idle(10);
    rd(3'd1, a); chk("R6 pin ignored in interval mode", a & 8'h0C, 8'h00);
    wr(3'd0, 8'h0B); idle(6);
    rd(3'd1, a); chk("R8 mode set gives rise", a & 8'h0C, 8'h04);
    rd(3'd3, a); chk("R8 rise value", a, v);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h03); idle(6);
    rd(3'd1, a); chk("R8 mode clear gives fall", a & 8'h0C, 8'h08);
    rd(3'd4, a); chk("R8 fall value", a, v);

    // R6 real edges with a new count
    cap_pin = 1'b0;
    watch_on = 1'b1; idle(40); watch_on = 1'b0; idle(20);
    rd(3'd2, v2);
    chk("R6 counter moved", {7'd0, v2 != v}, 8'h01);
    wr(3'd0, 8'h0B); idle(6); wr(3'd1, 8'h00);
    cap_pin = 1'b1; idle(8);
    rd(3'd1, a); chk("R6 rise flag", a & 8'h0C, 8'h04);
    rd(3'd3, a); chk("R6 rise capture", a, v2);
    cap_pin = 1'b0; idle(8);
    rd(3'd1, a); chk("R6 fall flag", a & 8'h0C, 8'h0C);
    rd(3'd4, a); chk("R6 fall capture", a, v2);

    // R10 counter write ignored
    wr(3'd2, 8'h55);
    rd(3'd2, a); chk("R10 count write ignored", a, v2);

    // R9 set wins over clear in the same cycle
    wr(3'd1, 8'h00); idle(2);
    cap_pin = 1'b1;
    idle(2);
    wr(3'd1, 8'h00);
    rd(3'd1, a); chk("R9 set wins", a & 8'h0C, 8'h04);

    // R7 noise canceller
    cap_pin = 1'b0; idle(10);
    wr(3'd0, 8'h1B); idle(20); wr(3'd1, 8'h00);
    cap_pin = 1'b1; idle(6); cap_pin = 1'b0; idle(30);
    rd(3'd1, a); chk("R7 short pulse dropped", a & 8'h0C, 8'h00);
    cap_pin = 1'b1; idle(3);
    rd(3'd1, a); chk("R7 no early strobe", a & 8'h0C, 8'h00);
    idle(36);
    rd(3'd1, a); chk("R7 long pulse rise", a & 8'h0C, 8'h04);
    cap_pin = 1'b0; idle(40);
    rd(3'd1, a); chk("R7 long pulse fall", a & 8'h0C, 8'h0C);

    // R11 source change keeps count
    rd(3'd2, v);
    wr(3'd0, 8'h02);
    rd(3'd2, a); chk("R11 count kept on select change", a, v);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule